// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host read and write a small bank of internal registers over a four-wire serial link. The link has an active-low select, a serial clock, a data input and a data output. Each transaction opens with a command byte. Bit 7 of that byte chooses write or read, and bits 6:0 give the register address. One, two or three data bytes follow, depending on how wide the addressed register is. All serial inputs are synchronized into the system clock domain, and clock edges are detected there. The serial clock must therefore run many times slower than the system clock.

Register widths are mixed. Data is right-justified and travels most significant byte first. Each written byte waits in a holding buffer for a fixed commit delay before it reaches the register. When it lands, the block shows it on a one-cycle write strobe port. That port carries the address, the byte lane (lane 0 is the least significant byte) and the data.

A configuration register holds a software reset bit. Writing that bit restores every register to its default value. The block then ignores the serial link for a hold-off period.

Top module: `sreg_slave`

## Requirements
- R1: After reset, every register holds its default value, (0xC3A500 + address) truncated to the register width. The data output is low and no strobe is issued.
- R2: The command byte is sampled MSB first on falling serial clock edges. Bit 7 = 1 selects write and 0 selects read; bits 6:0 give the address. Widths by address: 0→8, 1→12, 2→24, 3→16, 4→8 (configuration), 5→20, 6→24, 7→4 bits.
- R3: Data is right-justified. In a written byte, the bits that lie above the register width are cleared. For example, in a 12-bit register the upper nibble of the first byte is dropped.
- R4: A register takes ceil(width/8) data bytes. The first byte goes to the top lane (bytes−1) and later bytes go to lower lanes. Each committed byte appears as one strobe cycle carrying {address, lane, data}.
- R5: A completed byte is committed COMMIT_CYC system cycles after its last bit is detected. A byte that completes while an earlier byte is still waiting is discarded.
- R6: If select rises in the middle of a byte, the partial byte is not written. Bytes that were completed before it are still committed.
- R7: After the last byte of the addressed register, or after select rises, the next byte is taken as a command.
- R8: A read returns the register value right-justified in its byte count, MSB first. The data output changes after rising serial clock edges, so it is stable at the following falling edge.
- R9: Addresses at or above NUM_REGS take one data byte, read back as zero, and never produce a strobe.
- R10: Writing the configuration register (address CFG_ADDR) with bit SRST_BIT = 1 restores all defaults. For the next HOLDOFF_CYC cycles, serial traffic is ignored and nothing is written.
- R11: The data output is low while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, idle high |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| wr_stb | output | 1 | One-cycle commit strobe |
| wr_addr | output | 7 | Address of committed byte |
| wr_lane | output | 2 | Byte lane of committed byte |
| wr_data | output | 8 | Committed byte, masked to register width |

## Verification
The bench builds the block with COMMIT_CYC = 150 and HOLDOFF_CYC = 600, using a serial bit period of 16 system cycles. One byte then lasts 128 cycles, which is shorter than the commit delay. Sending data bytes back to back therefore lands a byte inside a pending commit, and the discard rule can be observed. A 40-cycle gap between bytes clears the delay for normal writes. A hold-off of 600 cycles is long enough to hold a complete refused write, and the bench then confirms through a read-back that defaults were restored.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int AW = 7;
    localparam int DW = 24;

    typedef enum logic [1:0] {
        PH_CMD = 2'd0,
        PH_WR  = 2'd1,
        PH_RD  = 2'd2
    } phase_e;

    // width in bits of each address (unmapped addresses behave as 8)
    function automatic int reg_bits(input logic [AW-1:0] a);
        case (a)
            7'd0:    return 8;
            7'd1:    return 12;
            7'd2:    return 24;
            7'd3:    return 16;
            7'd4:    return 8;
            7'd5:    return 20;
            7'd6:    return 24;
            7'd7:    return 4;
            default: return 8;
        endcase
    endfunction

    function automatic logic [1:0] reg_bytes(input logic [AW-1:0] a);
        int b;
        b = reg_bits(a);
        return 2'((b + 7) / 8);
    endfunction

    function automatic logic [7:0] lane_mask(input logic [AW-1:0] a, input logic [1:0] lane);
        int v;
        v = reg_bits(a) - 8 * int'(lane);
        if (v >= 8)      return 8'hFF;
        else if (v <= 0) return 8'h00;
        else             return 8'((1 << v) - 1);
    endfunction

    function automatic logic [DW-1:0] reg_default(input logic [AW-1:0] a);
        logic [31:0] full;
        full = 32'hC3A500 | {25'd0, a};
        return DW'(full & ((32'd1 << reg_bits(a)) - 32'd1));
    endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int             STAGES  = 2,
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stg
            logic [W-1:0] src;
            if (s == 0) begin : g_first
                assign src = din;
            end else begin : g_next
                assign src = stg_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= src;
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [1:0]    wlane,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DW-1:0] val [NUM_REGS];

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            localparam logic [AW-1:0] IDX = AW'(i);
            logic [DW-1:0] r_q, r_d;

            always_comb begin
                r_d = r_q;
                if (srst) begin
                    r_d = reg_default(IDX);
                end else if (we && waddr == IDX) begin
                    for (int l = 0; l < DW / 8; l++) begin
                        if (wlane == 2'(l)) r_d[8*l +: 8] = wdata;
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= reg_default(IDX);
                else        r_q <= r_d;
            end

            assign val[i] = r_q;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (int'(raddr) < NUM_REGS) rdata = val[raddr[IW-1:0]];
    end
endmodule

// File: rtl/sreg_holdoff.sv
module sreg_holdoff #(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = HW'(HOLD_CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
    import sreg_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int CFG_ADDR    = 4,
    parameter int SRST_BIT    = 0,
    parameter int COMMIT_CYC  = 8,
    parameter int HOLDOFF_CYC = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ss_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso,
    output logic       wr_stb,
    output logic [6:0] wr_addr,
    output logic [1:0] wr_lane,
    output logic [7:0] wr_data
);
    localparam int CW = (COMMIT_CYC > 1) ? $clog2(COMMIT_CYC + 1) : 1;

    typedef struct packed {
        phase_e        ph;
        logic [2:0]    bitc;
        logic [1:0]    left;
        logic [7:0]    sh;
        logic [AW-1:0] addr;
        logic [DW-1:0] rdsh;
        logic          miso;
        logic          sck_prev;
        logic          pend;
        logic [CW-1:0] pcnt;
        logic [AW-1:0] paddr;
        logic [1:0]    plane;
        logic [7:0]    pdata;
        logic          stb;
        logic [AW-1:0] saddr;
        logic [1:0]    slane;
        logic [7:0]    sdata;
    } state_t;

    localparam state_t RST_ST = '{ph: PH_CMD, sck_prev: 1'b1, default: '0};

    state_t st_q, st_d;

    // synchronized serial inputs
    logic [2:0] sync_s;
    logic       cs_act, sck_s, mosi_s;

    sreg_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b110)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ss_n, sck, mosi}),
        .dout (sync_s)
    );

    assign cs_act = ~sync_s[2];
    assign sck_s  = sync_s[1];
    assign mosi_s = sync_s[0];

    // software reset and hold-off
    logic busy, srst_hit;
    assign srst_hit = st_q.stb && (st_q.saddr == AW'(CFG_ADDR)) &&
                      (st_q.slane == 2'd0) && st_q.sdata[SRST_BIT];

    sreg_holdoff #(.HOLD_CYC(HOLDOFF_CYC)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .start(srst_hit),
        .busy (busy)
    );

    // register storage; read address is the command byte as it completes
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    assign rd_addr = {st_q.sh[5:0], mosi_s};

    sreg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .srst (srst_hit),
        .we   (st_q.stb),
        .waddr(st_q.saddr),
        .wlane(st_q.slane),
        .wdata(st_q.sdata),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    logic pend_w;
    assign pend_w = st_q.pend;

    function automatic logic is_mapped(input logic [AW-1:0] a);
        return int'(a) < NUM_REGS;
    endfunction

    always_comb begin
        logic [7:0] sh_n;
        logic [1:0] nb;
        logic [1:0] lane;
        logic       fall, rise;

        st_d          = st_q;
        st_d.stb      = 1'b0;
        st_d.sck_prev = sck_s;
        fall          = st_q.sck_prev & ~sck_s;
        rise          = ~st_q.sck_prev & sck_s;
        sh_n          = {st_q.sh[6:0], mosi_s};
        nb            = is_mapped(sh_n[6:0]) ? reg_bytes(sh_n[6:0]) : 2'd1;
        lane          = st_q.left - 2'd1;

        // commit path: holding buffer to register after fixed delay
        if (st_q.pend) begin
            if (st_q.pcnt == '0) begin
                st_d.pend  = 1'b0;
                st_d.stb   = 1'b1;
                st_d.saddr = st_q.paddr;
                st_d.slane = st_q.plane;
                st_d.sdata = st_q.pdata;
            end else begin
                st_d.pcnt = st_q.pcnt - 1'b1;
            end
        end

        if (!cs_act || busy) begin
            st_d.ph   = PH_CMD;
            st_d.bitc = '0;
            st_d.miso = 1'b0;
        end else if (fall) begin
            st_d.sh   = sh_n;
            st_d.bitc = st_q.bitc + 3'd1;
            if (st_q.bitc == 3'd7) begin
                unique case (st_q.ph)
                    PH_CMD: begin
                        st_d.addr = sh_n[6:0];
                        st_d.left = nb;
                        st_d.ph   = sh_n[7] ? PH_WR : PH_RD;
                        st_d.rdsh = rd_data << (8 * (3 - int'(nb)));
                    end
                    PH_WR: begin
                        if (!st_q.pend && is_mapped(st_q.addr)) begin
                            st_d.pend  = 1'b1;
                            st_d.pcnt  = CW'(COMMIT_CYC - 1);
                            st_d.paddr = st_q.addr;
                            st_d.plane = lane;
                            st_d.pdata = sh_n & lane_mask(st_q.addr, lane);
                        end
                        st_d.left = lane;
                        if (st_q.left == 2'd1) st_d.ph = PH_CMD;
                    end
                    default: begin
                        st_d.left = lane;
                        if (st_q.left == 2'd1) st_d.ph = PH_CMD;
                    end
                endcase
            end
        end else if (rise) begin
            if (st_q.ph == PH_RD) begin
                st_d.miso = st_q.rdsh[DW-1];
                st_d.rdsh = st_q.rdsh << 1;
            end else begin
                st_d.miso = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign miso    = st_q.miso;
    assign wr_stb  = st_q.stb;
    assign wr_addr = st_q.saddr;
    assign wr_lane = st_q.slane;
    assign wr_data = st_q.sdata;
endmodule

// File: rtl/sreg_slave_chk.sv
module sreg_slave_chk
    import sreg_pkg::*;
#(
    parameter int NUM_REGS   = 8,
    parameter int COMMIT_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_act,
    input logic       busy,
    input logic       pend,
    input logic       miso,
    input logic       wr_stb,
    input logic [6:0] wr_addr,
    input logic [1:0] wr_lane,
    input logic [7:0] wr_data
);
    int age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= 0;
        else        age_q <= pend ? age_q + 1 : 0;
    end

    // R11
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso);

    // R9
    mapped_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> int'(wr_addr) < NUM_REGS);

    // R3
    justified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_data & ~lane_mask(wr_addr, wr_lane)) == 8'h00);

    // R4
    lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> wr_lane < reg_bytes(wr_addr));

    // R5
    commit_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> age_q == COMMIT_CYC);

    // R10
    holdoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_stb);
endmodule

bind sreg_slave sreg_slave_chk #(.NUM_REGS(NUM_REGS), .COMMIT_CYC(COMMIT_CYC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_act (cs_act),
    .busy   (busy),
    .pend   (pend_w),
    .miso   (miso),
    .wr_stb (wr_stb),
    .wr_addr(wr_addr),
    .wr_lane(wr_lane),
    .wr_data(wr_data)
);

// File: tb/sreg_slave_tb.sv
module sreg_slave_tb;
    localparam int NREG   = 8;
    localparam int COMMIT = 150;
    localparam int HOLD   = 600;
    localparam int H      = 8;
    localparam int GAP    = 40;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, ss_n, sck, mosi;
    logic miso, wr_stb;
    logic [6:0] wr_addr;
    logic [1:0] wr_lane;
    logic [7:0] wr_data;

    sreg_slave #(.NUM_REGS(NREG), .CFG_ADDR(4), .SRST_BIT(0), .COMMIT_CYC(COMMIT),
                 .HOLDOFF_CYC(HOLD), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi), .miso(miso),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_lane(wr_lane), .wr_data(wr_data));

    int n_chk = 0;
    int n_bad = 0;
    logic [16:0] expq[$];
    logic [23:0] model [NREG];

    function automatic int w_bits(input int a);
        case (a)
            0: return 8;  1: return 12; 2: return 24; 3: return 16;
            4: return 8;  5: return 20; 6: return 24; 7: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic int n_of(input int a);
        return (a < NREG) ? (w_bits(a) + 7) / 8 : 1;
    endfunction

    function automatic logic [7:0] lmask(input int a, input int lane);
        int v;
        v = w_bits(a) - 8 * lane;
        if (v >= 8) return 8'hFF;
        if (v <= 0) return 8'h00;
        return 8'((1 << v) - 1);
    endfunction

    function automatic logic [23:0] dflt(input int a);
        logic [31:0] v;
        v = (32'hC3A500 + 32'(a)) & ((32'd1 << w_bits(a)) - 32'd1);
        return v[23:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected strobes as they appear
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R5/R9/R10 unexpected strobe", {7'd0, wr_addr, wr_lane, wr_data}, 24'h0);
            end else begin
                logic [16:0] e;
                e = expq.pop_front();
                chk({wr_addr, wr_lane, wr_data} == e, "R4 strobe contents",
                    {7'd0, wr_addr, wr_lane, wr_data}, {7'd0, e});
            end
        end
    end

    task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            repeat (H) @(negedge clk);
            r[i] = miso;
            sck = 1'b0;
            repeat (H) @(negedge clk);
            sck = 1'b1;
        end
    endtask

    task automatic cs_on();
        ss_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (H) @(negedge clk);
        ss_n = 1'b1;
        repeat (4 * H) @(negedge clk);
    endtask

    // driver: write body, pushes expected strobes and updates the model
    task automatic wr_body(input int a, input logic [23:0] v);
        logic [7:0] r;
        int nb;
        nb = n_of(a);
        xbyte({1'b1, 7'(a)}, r);
        for (int i = 0; i < nb; i++) begin
            int lane;
            logic [7:0] b, m;
            lane = nb - 1 - i;
            b = v[8*lane +: 8];
            if (a < NREG) begin
                m = b & lmask(a, lane);
                expq.push_back({7'(a), 2'(lane), m});
                model[a][8*lane +: 8] = m;
            end
            xbyte(b, r);
            repeat (GAP) @(negedge clk);
        end
    endtask

    task automatic rd_check(input int a, input string req);
        logic [7:0] r;
        logic [23:0] got, exp;
        int nb;
        nb = n_of(a);
        got = '0;
        xbyte({1'b0, 7'(a)}, r);
        for (int i = 0; i < nb; i++) begin
            xbyte(8'h00, r);
            got = {got[15:0], r};
        end
        exp = (a < NREG) ? model[a] : 24'h0;
        chk(got == exp, req, got, exp);
    endtask

    task automatic rd_txn(input int a, input string req);
        cs_on();
        rd_check(a, req);
        cs_off();
    endtask

    task automatic wr_txn(input int a, input logic [23:0] v);
        cs_on();
        wr_body(a, v);
        cs_off();
        repeat (COMMIT) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        for (int a = 0; a < NREG; a++) model[a] = dflt(a);
        rst_n = 1'b0; ss_n = 1'b1; sck = 1'b1; mosi = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk(miso == 1'b0, "R1 miso after reset", {23'd0, miso}, 24'h0);
        chk(wr_stb == 1'b0, "R1 no strobe after reset", {23'd0, wr_stb}, 24'h0);
        for (int a = 0; a < NREG; a++) rd_txn(a, "R1/R8 default read");

        // R2 write then read, 8-bit register
        wr_txn(0, 24'h00003C);
        rd_txn(0, "R2 write/read reg0");

        // R3 12-bit register: upper nibble of first byte dropped
        wr_txn(1, 24'h00FFAB);
        rd_txn(1, "R3 right-justified 12-bit");

        // R4 three-byte register, lanes high to low
        wr_txn(2, 24'h123456);
        rd_txn(2, "R4 24-bit lane order");

        // R7 back-to-back transfers in one select window
        cs_on();
        wr_body(0, 24'h000055);
        rd_check(7, "R7 command after completed write");
        cs_off();
        repeat (COMMIT) @(negedge clk);
        rd_txn(0, "R7 second write landed");
        chk(miso == 1'b0, "R11 miso idle", {23'd0, miso}, 24'h0);

        // R6 abort inside second byte of a 16-bit register
        cs_on();
        xbyte(8'h83, r);
        expq.push_back({7'd3, 2'd1, 8'h9A});
        model[3][15:8] = 8'h9A;
        xbyte(8'h9A, r);
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
            repeat (H) @(negedge clk);
            sck = 1'b1;
        end
        ss_n = 1'b1;
        repeat (COMMIT + 40) @(negedge clk);
        rd_txn(3, "R6 partial byte dropped");

        // R5 byte finishing inside commit delay is discarded
        cs_on();
        xbyte(8'h85, r);
        expq.push_back({7'd5, 2'd2, 8'h07});
        model[5][23:16] = 8'h07;
        xbyte(8'h07, r);
        xbyte(8'h11, r);
        expq.push_back({7'd5, 2'd0, 8'h22});
        model[5][7:0] = 8'h22;
        xbyte(8'h22, r);
        cs_off();
        repeat (COMMIT) @(negedge clk);
        rd_txn(5, "R5 overlapped byte discarded");

        // R9 unmapped address: one byte, zeros, no strobe
        cs_on();
        wr_body(66, 24'h0000A5);
        rd_check(66, "R9 unmapped read zero");
        rd_check(0, "R9 command follows single byte");
        cs_off();
        repeat (COMMIT) @(negedge clk);

        // R10 software reset and hold-off
        cs_on();
        wr_body(4, 24'h000001);
        cs_off();
        repeat (COMMIT) @(negedge clk);
        for (int a = 0; a < NREG; a++) model[a] = dflt(a);
        cs_on();
        xbyte(8'h80, r);
        xbyte(8'h77, r);
        cs_off();
        chk(miso == 1'b0, "R11 miso idle in hold-off", {23'd0, miso}, 24'h0);
        repeat (HOLD) @(negedge clk);
        rd_txn(0, "R10 reg0 default after soft reset");
        rd_txn(2, "R10 reg2 default after soft reset");
        rd_txn(4, "R10 config default after soft reset");

        repeat (COMMIT + 50) @(negedge clk);
        chk(expq.size() == 0, "R5 all expected strobes seen", 24'(expq.size()), 24'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule